// File: doc/BRIEF.md
# I2C SCL Clock Divider

This block turns a fast peripheral clock into the timing of an I2C serial clock line. It has two stages. A prescaler divides the peripheral clock by one plus a small divide field and gives a single-cycle enable pulse, the internal tick, in the system clock domain. Software picks the divide field so that the internal tick rate stays under 20 MHz. A phase controller counts internal ticks and sets the SCL period to 20 plus eight times a six-bit period-step field plus a compensation term. That term is the line's fall time, rise time and internal delay expressed in internal ticks and rounded up.

The divide field and the period-step field share one packed configuration word. The divide field sits in the low bits and the step field sits directly above it. The divide field is 2 or 3 bits wide, as a parameter selects, so the step field moves with it. The compensation term is loaded from its own input by the same write strobe. The low phase lasts the lower half of the period. The block then releases the line and waits until the synchronised line level reads high. Only then does it count the upper half, so a target that holds SCL low stretches the period. The block never drives SCL high. It only pulls the line low or releases it.

Top module: `scl_clock_divider`

## Requirements
- R1: After reset the line is released (`scl_oe`=0), `ick_tick` is 0, and both configuration readbacks are 0.
- R2: A `cfg_we` pulse while the controller is idle loads `cfg_word` and `cfg_dly`, and the stored values show on `cfg_word_q` and `cfg_dly_q` one cycle later.
- R3: A `cfg_we` pulse while the controller runs is ignored, and both readbacks keep their values.
- R4: With the divide field CDF = `cfg_word_q[CDF_W-1:0]`, `ick_tick` pulses once every 1+CDF clock cycles while running, inside a phase.
- R5: With SCGD = `cfg_word_q[CDF_W+5:CDF_W]`, D = `cfg_dly_q` and P = 20 + 8·SCGD + D, each low phase holds `scl_oe`=1 for floor(P/2)·(1+CDF) consecutive clock cycles.
- R6: When nothing holds the line, each released interval between low phases lasts SYNC_STAGES+1 + (P − floor(P/2))·(1+CDF) clock cycles. This covers the synchroniser delay plus the counted high phase.
- R7: If the line is held low for S extra cycles after release, the released interval grows by exactly S cycles.
- R8: When `run` is sampled high while the controller is idle, `scl_oe` is 1 after that same clock edge.
- R9: When `run` is sampled low, `scl_oe` and `ick_tick` are 0 after that edge and stay 0 while `run` stays low.
- R10: The parameter CDF_W (2 or 3) sets where SCGD starts. With CDF_W=2 the word 0x06 means CDF=2 and SCGD=1. With CDF_W=3 the same word means CDF=6 and SCGD=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System (peripheral) clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe, honoured only while idle |
| cfg_word | input | CDF_W+SCGD_W | Packed word: divide field low, period step above |
| cfg_dly | input | DLY_W | Compensation term in internal ticks |
| run | input | 1 | Generate SCL while high |
| scl_in | input | 1 | Sampled SCL line level |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| ick_tick | output | 1 | Internal-clock enable pulse |
| cfg_word_q | output | CDF_W+SCGD_W | Stored configuration word |
| cfg_dly_q | output | DLY_W | Stored compensation term |

## Verification
Several settings are used. The smallest period with no division exposes errors in the base count. A mid setting with an odd period separates the floor-half low phase from the ceiling-half high phase. A setting near the default timing assumptions adds a nonzero compensation term. The largest settings catch field truncation and counter width. A stretch test tells a high phase that counts from the observed high level apart from one that counts from release. The same packed word is sent to a 2-bit and a 3-bit divide-field instance to show where the step field starts. Writes made while running confirm the configuration lock.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

  localparam int unsigned BASE_TICKS = 20;
  localparam int unsigned SCGD_STEP  = 8;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;

  // full SCL period in internal ticks
  function automatic int unsigned period_ticks(input int unsigned step,
                                               input int unsigned comp);
    return BASE_TICKS + SCGD_STEP * step + comp;
  endfunction

  // low phase takes the lower half of the period
  function automatic int unsigned low_ticks(input int unsigned per);
    return per / 2;
  endfunction

  // high phase takes what remains
  function automatic int unsigned high_ticks(input int unsigned per);
    return per - (per / 2);
  endfunction

endpackage

// File: rtl/scl_cfg_reg.sv
module scl_cfg_reg #(
  parameter int unsigned WORD_W = 9,
  parameter int unsigned DLY_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              busy,
  input  logic [WORD_W-1:0] word_in,
  input  logic [DLY_W-1:0]  dly_in,
  output logic [WORD_W-1:0] word_q,
  output logic [DLY_W-1:0]  dly_q
);

  logic accept;
  assign accept = wr_en && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      dly_q  <= '0;
    end else if (accept) begin
      word_q <= word_in;
      dly_q  <= dly_in;
    end
  end

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int unsigned CDF_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             restart,
  input  logic [CDF_W-1:0] div_sel,
  output logic             tick
);

  logic [CDF_W-1:0] pc;

  assign tick = active && (pc == div_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= '0;
    end else if (restart || !active || tick) begin
      pc <= '0;
    end else begin
      pc <= pc + 1'b1;
    end
  end

endmodule

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  generate
    if (STAGES == 0) begin : g_bypass
      logic unused_ok;
      assign unused_ok = clk ^ rst_n;
      assign dout = din;
    end else if (STAGES == 1) begin : g_single
      logic q;
      always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b1;
        else        q <= din;
      end
      assign dout = q;
    end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk) begin
        if (!rst_n) sh <= '1;
        else        sh <= {sh[STAGES-2:0], din};
      end
      assign dout = sh[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_div_pkg::*;
#(
  parameter int unsigned PER_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             line_high,
  input  logic [PER_W-1:0] low_len,
  input  logic [PER_W-1:0] high_len,
  output logic             drive_low,
  output logic             busy,
  output logic             restart,
  output logic             phase_end
);

  phase_e           st, nxt;
  logic [PER_W-1:0] cnt;
  logic             low_last, high_last;

  assign low_last  = tick && (cnt == low_len  - PER_W'(1));
  assign high_last = tick && (cnt == high_len - PER_W'(1));

  always_comb begin
    nxt       = st;
    restart   = 1'b0;
    phase_end = 1'b0;
    if (!run) begin
      nxt = PH_IDLE;
    end else begin
      case (st)
        PH_IDLE: begin
          nxt     = PH_LOW;
          restart = 1'b1;
        end
        PH_LOW: begin
          if (low_last) begin
            nxt       = PH_WAIT;
            phase_end = 1'b1;
          end
        end
        PH_WAIT: begin
          if (line_high) begin
            nxt     = PH_HIGH;
            restart = 1'b1;
          end
        end
        default: begin
          if (high_last) begin
            nxt       = PH_LOW;
            restart   = 1'b1;
            phase_end = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= PH_IDLE;
      cnt <= '0;
    end else begin
      st <= nxt;
      if (nxt != st || restart) begin
        cnt <= '0;
      end else if (tick && (st == PH_LOW || st == PH_HIGH)) begin
        cnt <= cnt + PER_W'(1);
      end
    end
  end

  assign drive_low = (st == PH_LOW);
  assign busy      = (st != PH_IDLE);

endmodule

// File: rtl/scl_clock_divider.sv
module scl_clock_divider
  import scl_div_pkg::*;
#(
  parameter int unsigned CDF_W       = 3,
  parameter int unsigned SCGD_W      = 6,
  parameter int unsigned DLY_W       = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [CDF_W+SCGD_W-1:0] cfg_word,
  input  logic [DLY_W-1:0]        cfg_dly,
  input  logic                    run,
  input  logic                    scl_in,
  output logic                    scl_oe,
  output logic                    ick_tick,
  output logic [CDF_W+SCGD_W-1:0] cfg_word_q,
  output logic [DLY_W-1:0]        cfg_dly_q
);

  localparam int unsigned WORD_W  = CDF_W + SCGD_W;
  localparam int unsigned MAX_PER = BASE_TICKS + SCGD_STEP * ((1 << SCGD_W) - 1)
                                    + ((1 << DLY_W) - 1);
  localparam int unsigned PER_W   = $clog2(MAX_PER + 1);

  logic                busy;
  logic                phase_restart;
  logic                phase_end;
  logic                line_high;
  logic [CDF_W-1:0]    div_field;
  logic [SCGD_W-1:0]   step_field;
  logic [PER_W-1:0]    low_len, high_len;
  int unsigned         period;

  scl_cfg_reg #(.WORD_W(WORD_W), .DLY_W(DLY_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .busy    (busy),
    .word_in (cfg_word),
    .dly_in  (cfg_dly),
    .word_q  (cfg_word_q),
    .dly_q   (cfg_dly_q)
  );

  // field split: divide field low, period step directly above
  assign div_field  = cfg_word_q[CDF_W-1:0];
  assign step_field = cfg_word_q[CDF_W +: SCGD_W];

  always_comb begin
    period   = period_ticks(32'(step_field), 32'(cfg_dly_q));
    low_len  = PER_W'(low_ticks(period));
    high_len = PER_W'(high_ticks(period));
  end

  scl_prescaler #(.CDF_W(CDF_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (busy),
    .restart (phase_restart),
    .div_sel (div_field),
    .tick    (ick_tick)
  );

  scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (scl_in),
    .dout  (line_high)
  );

  scl_phase_fsm #(.PER_W(PER_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .tick      (ick_tick),
    .line_high (line_high),
    .low_len   (low_len),
    .high_len  (high_len),
    .drive_low (scl_oe),
    .busy      (busy),
    .restart   (phase_restart),
    .phase_end (phase_end)
  );

endmodule

// File: rtl/scl_clock_divider_chk.sv
module scl_clock_divider_chk
  import scl_div_pkg::*;
#(
  parameter int unsigned CDF_W  = 3,
  parameter int unsigned SCGD_W = 6,
  parameter int unsigned DLY_W  = 6
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    run,
  input logic                    cfg_we,
  input logic [CDF_W+SCGD_W-1:0] cfg_word,
  input logic [CDF_W+SCGD_W-1:0] cfg_word_q,
  input logic [DLY_W-1:0]        cfg_dly_q,
  input logic                    scl_oe,
  input logic                    ick_tick,
  input logic                    busy,
  input logic                    restart
);

  logic [7:0]  gap;
  logic        seen;
  logic [15:0] low_cnt;
  int unsigned exp_low;

  always_comb begin
    exp_low = low_ticks(period_ticks(32'(cfg_word_q[CDF_W +: SCGD_W]), 32'(cfg_dly_q)))
              * (32'(cfg_word_q[CDF_W-1:0]) + 32'd1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !busy) begin
      gap  <= 8'd0;
      seen <= 1'b0;
    end else if (ick_tick) begin
      gap  <= 8'd1;
      seen <= 1'b1;
    end else if (gap != 8'hFF) begin
      gap <= gap + 8'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !scl_oe) low_cnt <= 16'd0;
    else                   low_cnt <= low_cnt + 16'd1;
  end

  assert_cfg_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !busy) |=> (cfg_word_q == $past(cfg_word)));

  assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(cfg_word_q) && $stable(cfg_dly_q)));

  assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ick_tick && seen) |-> (gap == 8'(cfg_word_q[CDF_W-1:0]) + 8'd1));

  assert_low_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_oe) && $past(run)) |-> (32'(low_cnt) == exp_low));

  assert_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !busy) |=> scl_oe);

  assert_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!scl_oe && !ick_tick));

endmodule

bind scl_clock_divider scl_clock_divider_chk #(
  .CDF_W(CDF_W), .SCGD_W(SCGD_W), .DLY_W(DLY_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .cfg_we     (cfg_we),
  .cfg_word   (cfg_word),
  .cfg_word_q (cfg_word_q),
  .cfg_dly_q  (cfg_dly_q),
  .scl_oe     (scl_oe),
  .ick_tick   (ick_tick),
  .busy       (busy),
  .restart    (phase_restart)
);

// File: tb/scl_clock_divider_bench.sv
module scl_clock_divider_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  // wide instance: 3-bit divide field
  logic       we_w = 1'b0, run_w = 1'b0, hold_w = 1'b0;
  logic [8:0] word_w = '0, word_q_w;
  logic [5:0] dly_w = '0, dly_q_w;
  logic       oe_w, tick_w, line_w;
  assign line_w = !oe_w && !hold_w;

  scl_clock_divider #(.CDF_W(3)) u_scl_clock_divider (
    .clk(clk), .rst_n(rst_n), .cfg_we(we_w), .cfg_word(word_w), .cfg_dly(dly_w),
    .run(run_w), .scl_in(line_w), .scl_oe(oe_w), .ick_tick(tick_w),
    .cfg_word_q(word_q_w), .cfg_dly_q(dly_q_w));

  // narrow instance: 2-bit divide field
  logic       we_n = 1'b0, run_n = 1'b0;
  logic [7:0] word_n = '0, word_q_n;
  logic [5:0] dly_n = '0, dly_q_n;
  logic       oe_n, tick_n, line_n;
  assign line_n = !oe_n;

  scl_clock_divider #(.CDF_W(2)) u_scl_clock_divider_narrow (
    .clk(clk), .rst_n(rst_n), .cfg_we(we_n), .cfg_word(word_n), .cfg_dly(dly_n),
    .run(run_n), .scl_in(line_n), .scl_oe(oe_n), .ick_tick(tick_n),
    .cfg_word_q(word_q_n), .cfg_dly_q(dly_q_n));

  int errors = 0;
  int checks = 0;

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int per_of(input int step, input int comp);
    return 20 + 8 * step + comp;
  endfunction

  function automatic int exp_low(input int div, input int step, input int comp);
    int p = per_of(step, comp);
    return (p / 2) * (div + 1);
  endfunction

  function automatic int exp_rel(input int div, input int step, input int comp, input int s);
    int p = per_of(step, comp);
    return s + 3 + (p - p / 2) * (div + 1);
  endfunction

  task automatic wr_wide(input int div, input int step, input int comp);
    @(negedge clk);
    word_w = 9'((step << 3) | div);
    dly_w  = 6'(comp);
    we_w   = 1'b1;
    @(negedge clk);
    we_w   = 1'b0;
  endtask

  // start, measure first low phase and the released interval, stop
  task automatic measure_wide(input int s, output int lo, output int rel);
    @(negedge clk);
    run_w = 1'b1;
    @(negedge clk);
    lo = 0;
    while (oe_w) begin lo++; @(negedge clk); end
    rel = 0;
    while (!oe_w && rel < 5000) begin
      rel++;
      if (rel == 1 && s > 0) hold_w = 1'b1;
      if (rel == 1 + s) hold_w = 1'b0;
      @(negedge clk);
    end
    hold_w = 1'b0;
    run_w  = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check_eq("R1 scl_oe after reset", int'(oe_w), 0);
    check_eq("R1 ick_tick after reset", int'(tick_w), 0);
    check_eq("R1 cfg_word_q after reset", int'(word_q_w), 0);
    check_eq("R1 cfg_dly_q after reset", int'(dly_q_w), 0);
  endtask

  task automatic t_cfg_load;
    wr_wide(5, 17, 9);
    check_eq("R2 word readback", int'(word_q_w), (17 << 3) | 5);
    check_eq("R2 dly readback", int'(dly_q_w), 9);
  endtask

  task automatic t_period(input string tag, input int div, input int step, input int comp);
    int lo, rel;
    wr_wide(div, step, comp);
    measure_wide(0, lo, rel);
    check_eq({"R5 low phase ", tag}, lo, exp_low(div, step, comp));
    check_eq({"R6 released interval ", tag}, rel, exp_rel(div, step, comp, 0));
  endtask

  task automatic t_stretch;
    int lo, rel;
    wr_wide(1, 2, 3);
    measure_wide(25, lo, rel);
    check_eq("R7 low phase with stretch", lo, exp_low(1, 2, 3));
    check_eq("R7 stretched released interval", rel, exp_rel(1, 2, 3, 25));
  endtask

  task automatic t_tick_gap(input int div);
    int n = 0;
    wr_wide(div, 4, 0);
    @(negedge clk);
    run_w = 1'b1;
    @(negedge clk);
    while (!tick_w) @(negedge clk);
    do begin @(negedge clk); n++; end while (!tick_w && n < 100);
    check_eq("R4 tick spacing", n, div + 1);
    run_w = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_start_stop;
    int seen_tick = 0;
    wr_wide(2, 3, 1);
    @(negedge clk);
    run_w = 1'b1;
    @(negedge clk);
    check_eq("R8 scl_oe one edge after run", int'(oe_w), 1);
    repeat (7) @(negedge clk);
    run_w = 1'b0;
    @(negedge clk);
    check_eq("R9 scl_oe released after stop", int'(oe_w), 0);
    check_eq("R9 ick_tick stopped", int'(tick_w), 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (tick_w || oe_w) seen_tick++;
    end
    check_eq("R9 quiet while stopped", seen_tick, 0);
  endtask

  task automatic t_locked;
    int lo, rel;
    wr_wide(0, 0, 0);
    @(negedge clk);
    run_w = 1'b1;
    repeat (3) @(negedge clk);
    word_w = 9'h1FF;
    dly_w  = 6'h3F;
    we_w   = 1'b1;
    @(negedge clk);
    we_w   = 1'b0;
    @(negedge clk);
    check_eq("R3 word unchanged while running", int'(word_q_w), 0);
    check_eq("R3 dly unchanged while running", int'(dly_q_w), 0);
    run_w = 1'b0;
    repeat (2) @(negedge clk);
    measure_wide(0, lo, rel);
    check_eq("R3 period still from old settings", lo, exp_low(0, 0, 0));
  endtask

  task automatic t_field_width;
    int lo = 0, lo_w, rel_w;
    @(negedge clk);
    word_n = 8'h06;
    dly_n  = 6'd0;
    we_n   = 1'b1;
    @(negedge clk);
    we_n   = 1'b0;
    run_n  = 1'b1;
    @(negedge clk);
    while (oe_n) begin lo++; @(negedge clk); end
    run_n = 1'b0;
    check_eq("R10 narrow field low phase", lo, exp_low(2, 1, 0));
    @(negedge clk);
    word_w = 9'h006;
    dly_w  = 6'd0;
    we_w   = 1'b1;
    @(negedge clk);
    we_w   = 1'b0;
    measure_wide(0, lo_w, rel_w);
    check_eq("R10 wide field low phase", lo_w, exp_low(6, 0, 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cfg_load();
    t_period("minimum", 0, 0, 0);
    t_period("odd period", 3, 2, 5);
    t_period("default timing", 4, 1, 6);
    t_period("maximum", 7, 63, 63);
    t_stretch();
    t_tick_gap(3);
    t_tick_gap(0);
    t_start_stop();
    t_locked();
    t_field_width();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule